// File: doc/BRIEF.md
# GPIO Bank Register File with Write Protection

This block is the register file of a general-purpose I/O controller. It holds the output level and direction of up to eight banks of 32 pins each, and reports the live input level of every pin. Software reaches it through a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. The pin-side vectors (`pin_out_o`, `pin_dir_o`, `pin_in_i`) connect to the pad ring. Pin n sits in bank n >> 5 at bit n & 31.

Every bank starts locked. To change a bank, software first writes the key 0x00A5A501 to the global key register. The very next write must go to that bank's lock register. All zeros there unlocks the bank, and all ones locks it again. Software never writes the output level directly. It writes a mask to a set register or to a clear register, so a read-modify-write is never needed to change one pin.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every bank is locked (its lock register reads 0xFFFFFFFF), every pin is an input (`pin_dir_o` all ones, control word reads 1), and `pin_out_o` is all zeros.
- R2: A write of 0x00A5A501 to the key register (0x520), followed directly by a write of 0x00000000 to bank b's lock register (0x500 + 4b), unlocks bank b. The lock register then reads 0x00000000.
- R3: A lock-register write is discarded unless the immediately preceding write was the correct key. Any other write in between, to any address, disarms the key.
- R4: An armed lock write of 0xFFFFFFFF locks the bank. An armed lock write of any value other than all zeros or all ones leaves the lock state unchanged and still consumes the key.
- R5: In an unlocked bank, a write to the set register (0x040 + 4b) drives high each pin whose data bit is 1. Pins at 0 bits keep their level.
- R6: In an unlocked bank, a write to the clear register (0x060 + 4b) drives low each pin whose data bit is 1. Pins at 0 bits keep their level.
- R7: The control word of pin n sits at 0x100 + 4n. Bit 0 is the direction: 1 means input and 0 means output. This bit drives `pin_dir_o[n]`. Reads return the direction in bit 0 and zeros in bits 31:1.
- R8: While a bank is locked, writes to its set, clear and control registers have no effect. Its registers still read back their current values.
- R9: The input status register (0x020 + 4b) reads the current value of `pin_in_i` for bank b.
- R10: The set, clear and key registers read as zero.
- R11: Lock state is held per bank. Unlocking one bank lets writes through to that bank only, and pin 255 maps to bank 7, bit 31.
- R12: The output status register (0x000 + 4b) reads the bank's output levels. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register access |
| we_i | input | 1 | Write strobe; the write happens on the next rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_in_i | input | NUM_BANKS*32 | Input level of each pin |
| pin_out_o | output | NUM_BANKS*32 | Output level of each pin |
| pin_dir_o | output | NUM_BANKS*32 | Direction of each pin, 1 = input |

## Verification
The bench targets the unlock sequence where it is easiest to get wrong.

- A key followed by an unrelated write and then a lock write must leave the bank locked. A design that only disarms on the lock write would unlock it.
- An armed lock write with a value that is neither all zeros nor all ones must change nothing. A design that tests only one bit would flip the lock.
- Zero bits in a set or clear mask must leave their pins alone. A design that copies the mask would clear or set neighbouring pins.
- Writes to a locked neighbour bank and to a relocked bank must not move any pin.
- Pin 255 is checked to catch an off-by-one in the bank-to-pin mapping.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int MAX_BANKS = 8;

  localparam logic [DATA_W-1:0] KEY_VAL   = 32'h00A5_A501;
  localparam logic [DATA_W-1:0] CODE_OPEN = '0;
  localparam logic [DATA_W-1:0] CODE_SHUT = '1;

  // address bits [11:5] select a group of per-bank words
  localparam logic [6:0] GRP_OUT  = 7'h00;
  localparam logic [6:0] GRP_IN   = 7'h01;
  localparam logic [6:0] GRP_SET  = 7'h02;
  localparam logic [6:0] GRP_CLR  = 7'h03;
  localparam logic [6:0] GRP_LOCK = 7'h28;
  localparam logic [6:0] GRP_KEY  = 7'h29;
  localparam int CTRL_WORD0 = 64;  // 0x100 >> 2

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OUT, SEL_IN, SEL_SET, SEL_CLR, SEL_CTRL, SEL_LOCK, SEL_KEY
  } reg_sel_e;
endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BIDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  key_hit_i,
  input  logic                  lock_hit_i,
  input  logic [BIDX_W-1:0]     bank_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [NUM_BANKS-1:0]  locked_o
);
  logic armed_q;

  // key arms exactly one following write; every write re-evaluates it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= key_hit_i && (wdata_i == KEY_VAL);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        locked_o[b] <= 1'b1;
      end else if (wr_i && lock_hit_i && armed_q && bank_i == BIDX_W'(b)) begin
        if (wdata_i == CODE_OPEN)      locked_o[b] <= 1'b0;
        else if (wdata_i == CODE_SHUT) locked_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BIDX_W = 3,
  localparam int NPINS = NUM_BANKS * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_wr_i,
  input  logic                  clr_wr_i,
  input  logic [BIDX_W-1:0]     bank_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_BANKS-1:0]  locked_i,
  output logic [NPINS-1:0]      out_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BIDX_W'(b)) && !locked_i[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        out_o[b*DATA_W +: DATA_W] <= '0;
      else if (hit && set_wr_i)
        out_o[b*DATA_W +: DATA_W] <= out_o[b*DATA_W +: DATA_W] | wdata_i;
      else if (hit && clr_wr_i)
        out_o[b*DATA_W +: DATA_W] <= out_o[b*DATA_W +: DATA_W] & ~wdata_i;
    end
  end
endmodule

// File: rtl/gpio_dir_regs.sv
module gpio_dir_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int NPINS = NUM_BANKS * DATA_W,
  localparam int PIDX_W = $clog2(NPINS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_wr_i,
  input  logic [PIDX_W-1:0]     pin_i,
  input  logic                  dir_bit_i,
  input  logic [NUM_BANKS-1:0]  locked_i,
  output logic [NPINS-1:0]      dir_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        dir_o[p] <= 1'b1;
      else if (ctrl_wr_i && pin_i == PIDX_W'(p) && !locked_i[p / DATA_W])
        dir_o[p] <= dir_bit_i;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_BANKS*DATA_W-1:0]   pin_in_i,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_out_o,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_dir_o
);
  localparam int NPINS  = NUM_BANKS * DATA_W;
  localparam int BIDX_W = 3;
  localparam int PIDX_W = $clog2(NPINS);
  localparam int WORD_W = ADDR_W - 2;

  reg_sel_e                sel;
  logic [BIDX_W-1:0]       bidx;
  logic [PIDX_W-1:0]       pidx;
  logic [WORD_W-1:0]       word;
  logic                    bank_ok;
  logic [NUM_BANKS-1:0]    locked;

  assign word    = addr_i[ADDR_W-1:2];
  assign bidx    = addr_i[4:2];
  assign bank_ok = int'(bidx) < NUM_BANKS;
  assign pidx    = PIDX_W'(int'(word) - CTRL_WORD0);

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (int'(word) >= CTRL_WORD0 && int'(word) < CTRL_WORD0 + NPINS) begin
        sel = SEL_CTRL;
      end else begin
        unique case (addr_i[ADDR_W-1:5])
          GRP_OUT:  if (bank_ok) sel = SEL_OUT;
          GRP_IN:   if (bank_ok) sel = SEL_IN;
          GRP_SET:  if (bank_ok) sel = SEL_SET;
          GRP_CLR:  if (bank_ok) sel = SEL_CLR;
          GRP_LOCK: if (bank_ok) sel = SEL_LOCK;
          GRP_KEY:  if (bidx == '0) sel = SEL_KEY;
          default:  sel = SEL_NONE;
        endcase
      end
    end
  end

  gpio_lock_ctrl #(.NUM_BANKS(NUM_BANKS)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i),
    .key_hit_i  (sel == SEL_KEY),
    .lock_hit_i (sel == SEL_LOCK),
    .bank_i     (bidx),
    .wdata_i    (wdata_i),
    .locked_o   (locked)
  );

  gpio_out_regs #(.NUM_BANKS(NUM_BANKS)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wr_i (we_i && sel == SEL_SET),
    .clr_wr_i (we_i && sel == SEL_CLR),
    .bank_i   (bidx),
    .wdata_i  (wdata_i),
    .locked_i (locked),
    .out_o    (pin_out_o)
  );

  gpio_dir_regs #(.NUM_BANKS(NUM_BANKS)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (we_i && sel == SEL_CTRL),
    .pin_i     (pidx),
    .dir_bit_i (wdata_i[0]),
    .locked_i  (locked),
    .dir_o     (pin_dir_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_OUT:  rdata_o = pin_out_o[int'(bidx)*DATA_W +: DATA_W];
      SEL_IN:   rdata_o = pin_in_i[int'(bidx)*DATA_W +: DATA_W];
      SEL_LOCK: rdata_o = {DATA_W{locked[bidx]}};
      SEL_CTRL: rdata_o = {{(DATA_W-1){1'b0}}, pin_dir_o[pidx]};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         we_i,
  input logic [DATA_W-1:0]            wdata_i,
  input logic [NUM_BANKS*DATA_W-1:0]  pin_out_o,
  input logic [NUM_BANKS*DATA_W-1:0]  pin_dir_o,
  input logic [NUM_BANKS-1:0]         locked
);
  logic [2:0] bk;
  logic       grp_set, grp_clr, grp_lock, grp_ctrl, key_wr, key_seen_q, bk_locked;

  assign bk        = addr_i[4:2];
  assign bk_locked = (int'(bk) < NUM_BANKS) ? locked[bk] : 1'b1;
  assign grp_set   = we_i && addr_i[11:5] == GRP_SET && addr_i[1:0] == 2'b00;
  assign grp_clr   = we_i && addr_i[11:5] == GRP_CLR && addr_i[1:0] == 2'b00;
  assign grp_lock  = we_i && addr_i[11:5] == GRP_LOCK;
  assign grp_ctrl  = we_i && addr_i[11:8] != 4'h0 && addr_i[11:8] < 4'h5;
  assign key_wr    = we_i && addr_i == 12'h520 && wdata_i == KEY_VAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_seen_q <= 1'b0;
    else if (we_i) key_seen_q <= key_wr;
  end

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (&locked && pin_out_o == '0 && &pin_dir_o)); // R1

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(locked) |-> ($past(grp_lock) && $past(key_seen_q))); // R3

  AST_SET_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_set && !bk_locked) |=>
      ((pin_out_o[int'($past(bk))*DATA_W +: DATA_W] & $past(wdata_i)) == $past(wdata_i))); // R5

  AST_CLR_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_clr && !bk_locked) |=>
      ((pin_out_o[int'($past(bk))*DATA_W +: DATA_W] & $past(wdata_i)) == '0)); // R6

  AST_LOCKED_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grp_set || grp_clr) && bk_locked) |=> $stable(pin_out_o)); // R8

  AST_LOCKED_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_ctrl && &locked) |=> $stable(pin_dir_o)); // R8
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .pin_out_o (pin_out_o),
  .pin_dir_o (pin_dir_o),
  .locked    (locked)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  localparam int NB = 8;
  localparam int NP = NB * 32;
  localparam logic [31:0] KEY = 32'h00A5_A501;
  // {write, req, addr, data}; for reads data is the expected value
  localparam int NV = 53;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 4'd1,  12'h500, 32'hFFFF_FFFF},  // R1
    {1'b0, 4'd1,  12'h51C, 32'hFFFF_FFFF},  // R1
    {1'b0, 4'd1,  12'h000, 32'h0000_0000},  // R1
    {1'b0, 4'd1,  12'h100, 32'h0000_0001},  // R1
    {1'b1, 4'd8,  12'h040, 32'h0000_FFFF},  // R8
    {1'b0, 4'd8,  12'h000, 32'h0000_0000},  // R8
    {1'b1, 4'd3,  12'h500, 32'h0000_0000},  // R3 no key
    {1'b0, 4'd3,  12'h500, 32'hFFFF_FFFF},  // R3
    {1'b1, 4'd3,  12'h520, KEY},            // R3 key then other write
    {1'b1, 4'd12, 12'h000, 32'h0000_1234},  // R12
    {1'b1, 4'd3,  12'h500, 32'h0000_0000},  // R3
    {1'b0, 4'd3,  12'h500, 32'hFFFF_FFFF},  // R3
    {1'b0, 4'd12, 12'h000, 32'h0000_0000},  // R12
    {1'b1, 4'd2,  12'h520, KEY},            // R2
    {1'b1, 4'd2,  12'h500, 32'h0000_0000},  // R2
    {1'b0, 4'd2,  12'h500, 32'h0000_0000},  // R2
    {1'b0, 4'd11, 12'h504, 32'hFFFF_FFFF},  // R11
    {1'b1, 4'd5,  12'h040, 32'hF0F0_00FF},  // R5
    {1'b0, 4'd5,  12'h000, 32'hF0F0_00FF},  // R5
    {1'b1, 4'd5,  12'h040, 32'h0000_0000},  // R5
    {1'b0, 4'd5,  12'h000, 32'hF0F0_00FF},  // R5
    {1'b1, 4'd6,  12'h060, 32'h0000_00F0},  // R6
    {1'b0, 4'd6,  12'h000, 32'hF0F0_000F},  // R6
    {1'b0, 4'd10, 12'h040, 32'h0000_0000},  // R10
    {1'b0, 4'd10, 12'h060, 32'h0000_0000},  // R10
    {1'b0, 4'd10, 12'h520, 32'h0000_0000},  // R10
    {1'b1, 4'd12, 12'h000, 32'hFFFF_FFFF},  // R12
    {1'b0, 4'd12, 12'h000, 32'hF0F0_000F},  // R12
    {1'b1, 4'd7,  12'h100, 32'h0000_0000},  // R7
    {1'b0, 4'd7,  12'h100, 32'h0000_0000},  // R7
    {1'b1, 4'd7,  12'h104, 32'hFFFF_FFFF},  // R7
    {1'b0, 4'd7,  12'h104, 32'h0000_0001},  // R7
    {1'b1, 4'd8,  12'h180, 32'h0000_0000},  // R8 pin 32, bank 1 locked
    {1'b0, 4'd8,  12'h180, 32'h0000_0001},  // R8
    {1'b1, 4'd8,  12'h044, 32'hFFFF_FFFF},  // R8
    {1'b0, 4'd8,  12'h004, 32'h0000_0000},  // R8
    {1'b1, 4'd4,  12'h520, KEY},            // R4
    {1'b1, 4'd4,  12'h500, 32'h1234_5678},  // R4 odd code
    {1'b0, 4'd4,  12'h500, 32'h0000_0000},  // R4
    {1'b1, 4'd4,  12'h520, KEY},            // R4
    {1'b1, 4'd4,  12'h500, 32'hFFFF_FFFF},  // R4 relock
    {1'b0, 4'd4,  12'h500, 32'hFFFF_FFFF},  // R4
    {1'b1, 4'd8,  12'h060, 32'hFFFF_FFFF},  // R8
    {1'b0, 4'd8,  12'h000, 32'hF0F0_000F},  // R8
    {1'b1, 4'd8,  12'h104, 32'h0000_0000},  // R8
    {1'b0, 4'd8,  12'h104, 32'h0000_0001},  // R8
    {1'b1, 4'd11, 12'h520, KEY},            // R11
    {1'b1, 4'd11, 12'h51C, 32'h0000_0000},  // R11
    {1'b0, 4'd11, 12'h51C, 32'h0000_0000},  // R11
    {1'b1, 4'd11, 12'h05C, 32'h8000_0000},  // R11 pin 255
    {1'b0, 4'd11, 12'h01C, 32'h8000_0000},  // R11
    {1'b0, 4'd11, 12'h500, 32'hFFFF_FFFF},  // R11
    {1'b0, 4'd11, 12'h000, 32'hF0F0_000F}   // R11
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [11:0]   addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_in_i = '0;
  logic [NP-1:0] pin_out_o, pin_dir_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_bank_regs #(.NUM_BANKS(NB)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_dir_o(pin_dir_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_rd(input string req, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    #1 check(req, rdata_o, e);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", {31'b0, &pin_dir_o}, 32'd1);
    check("R1", {31'b0, |pin_out_o}, 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) bus_wr(VEC[i][43:32], VEC[i][31:0]);
      else bus_rd($sformatf("R%0d", VEC[i][47:44]), VEC[i][43:32], VEC[i][31:0]);
    end
    // pin-side view of the table's results
    @(negedge clk_i);
    check("R5", pin_out_o[31:0], 32'hF0F0_000F);
    check("R11", pin_out_o[255:224], 32'h8000_0000);
    check("R7", {30'b0, pin_dir_o[1:0]}, 32'd2);
    // R9 input status
    pin_in_i[31:0] = 32'h1234_5678;
    pin_in_i[63:32] = 32'hA5C3_0F1E;
    bus_rd("R9", 12'h020, 32'h1234_5678);
    bus_rd("R9", 12'h024, 32'hA5C3_0F1E);
    pin_in_i[31:0] = 32'hFFFF_0000;
    bus_rd("R9", 12'h020, 32'hFFFF_0000);
    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", {31'b0, |pin_out_o}, 32'd0);
    check("R1", {31'b0, &pin_dir_o}, 32'd1);
    rst_ni = 1'b1;
    bus_rd("R1", 12'h51C, 32'hFFFF_FFFF);
    bus_rd("R1", 12'h100, 32'h0000_0001);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule